// File: doc/BRIEF.md
# Link Register and Return-Address Predictor

This block keeps a dedicated link register, apart from the general-purpose register file. A small ring of recent return addresses sits beside it and predicts return targets. The front end issues one operation at a time on a valid/ready port. The block accepts eight operations: a plain call, a return through the link register, saving the link to the memory stack, restoring it from that stack, a fused save-then-call, a fused restore-then-return, an indirect jump through some other register, and a no-op. A plain call only updates the link register, so a leaf function costs no memory traffic. Saving and restoring travel over a simple request/response memory port, and the block keeps the stack pointer used for these transfers.

On every return the block reports the actual target and the predicted target, with the prediction's validity. It raises a one-cycle mispredict flag when the prediction is missing or differs from the actual target. Calls push the ring and returns pop it. When the ring is full, the oldest entry is overwritten. An indirect jump through another register leaves the ring and the link register untouched.

Top module: `link_unit`

## Requirements
- R1: After reset the link register reads 0, the stack pointer reads SP_INIT (0x1000), op_ready_o is 1, and mem_req_valid_o, ret_valid_o, pred_valid_o and mispredict_o are 0.
- R2: A call (op code 1) loads ret_addr_i into the link register, visible on lr_o one cycle after acceptance, and issues no memory request.
- R3: A return (op code 2) raises ret_valid_o one cycle after acceptance for exactly that cycle, with ret_target_o equal to the link register. pred_target_o then equals the return address of the most recent call not yet consumed by a return, in last-in first-out order.
- R4: With a return, mispredict_o is 1 when pred_valid_o is 0 or pred_target_o differs from ret_target_o, and 0 otherwise. mispredict_o is never 1 without ret_valid_o.
- R5: The predictor holds 8 entries. After more than 8 calls, returns predict the 8 newest return addresses newest first, and the next return reports pred_valid_o = 0.
- R6: An indirect jump through another register (op code 7) changes neither the link register nor the predictor and produces no return report.
- R7: Push-link (op code 3) holds a write request (mem_we_o = 1) at address SP-8 with data equal to the link register until mem_req_ready_i. The stack pointer drops by 8 at the handshake, and op_ready_o stays 0 until then.
- R8: Pop-link (op code 4) issues a read request (mem_we_o = 0) at address SP. On the response, the link register takes mem_rdata_i and the stack pointer rises by 8. The stack pointer only ever moves in steps of 8.
- R9: Push-link-then-call (op code 5) first writes the old link register to SP-8, then loads ret_addr_i into the link register and pushes it onto the predictor.
- R10: Pop-link-then-return (op code 6) reads SP, restores the link register from the response, and reports a return to the restored address with the predictor popped and compared as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_i | input | 3 | Operation code (0 none, 1 call, 2 return, 3 push-link, 4 pop-link, 5 push+call, 6 pop+return, 7 indirect jump) |
| ret_addr_i | input | AW | Return address written by a call |
| op_ready_o | output | 1 | Block idle, operation accepted this cycle |
| lr_o | output | AW | Link register |
| sp_o | output | AW | Stack pointer used for link save/restore |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | AW | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | AW | Read data |
| ret_valid_o | output | 1 | Return resolved this cycle |
| ret_target_o | output | AW | Actual return target |
| pred_valid_o | output | 1 | Predictor had an entry for this return |
| pred_target_o | output | AW | Predicted return target |
| mispredict_o | output | 1 | Prediction missing or wrong |

## Verification
A corrupted ring pointer or occupancy count surfaces at the next return, one cycle after it is accepted, as a wrong pred_target_o, a wrong pred_valid_o or a spurious mispredict_o. The LIFO nesting, overflow and drained-ring cases are set up to expose exactly those faults. A wrong stack pointer or link register shows on the very next memory request as a bad address or write data, and on sp_o and lr_o once the sequence completes. The fused operations are checked for both the memory side and the predictor side of the same sequence.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_CALL      = 3'd1,
    OP_RET       = 3'd2,
    OP_PUSH      = 3'd3,
    OP_POP       = 3'd4,
    OP_PUSH_CALL = 3'd5,
    OP_POP_RET   = 3'd6,
    OP_JIND      = 3'd7
  } link_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_RD_REQ,
    ST_RD_WAIT
  } seq_state_e;
endpackage

// File: rtl/ret_ring.sv
module ret_ring #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          top_valid_o,
  output logic [AW-1:0] top_data_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] top_idx;
  logic [AW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               val_q <= '0;
      else if (push_i && wr_ptr_q == PW'(g))     val_q <= push_data_i;
    end
    assign ent[g] = val_q;
  end

  assign top_idx     = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;
  assign top_valid_o = (cnt_q != '0);
  assign top_data_o  = ent[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;  // full: oldest overwritten
    end else if (pop_i && cnt_q != '0) begin
      wr_ptr_q <= top_idx;
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  assert_push_pop_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));

  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !top_valid_o |=> !top_valid_o && $stable(wr_ptr_q));
endmodule

// File: rtl/link_seq.sv
module link_seq
  import link_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   SLOT_BYTES = 8,
  parameter logic [AW-1:0] SP_INIT    = 'h1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  link_op_e      op_i,
  input  logic [AW-1:0] ret_addr_i,
  output logic          op_ready_o,
  output logic [AW-1:0] lr_o,
  output logic [AW-1:0] sp_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          pred_push_o,
  output logic [AW-1:0] pred_data_o,
  output logic          ret_fire_o,
  output logic [AW-1:0] ret_target_o
);
  localparam logic [AW-1:0] STEP = AW'(SLOT_BYTES);

  seq_state_e    state_q;
  logic          fused_q;
  logic [AW-1:0] ra_q, lr_q, sp_q;
  logic          accept, wr_done, rd_done;

  assign accept     = op_valid_i && (state_q == ST_IDLE);
  assign op_ready_o = (state_q == ST_IDLE);
  assign wr_done    = (state_q == ST_WR) && mem_req_ready_i;
  assign rd_done    = (state_q == ST_RD_WAIT) && mem_rsp_valid_i;
  assign lr_o       = lr_q;
  assign sp_o       = sp_q;

  assign mem_req_valid_o = (state_q == ST_WR) || (state_q == ST_RD_REQ);
  assign mem_we_o        = (state_q == ST_WR);
  assign mem_addr_o      = (state_q == ST_WR) ? sp_q - STEP : sp_q;
  assign mem_wdata_o     = lr_q;

  assign pred_push_o  = (accept && op_i == OP_CALL) || (wr_done && fused_q);
  assign pred_data_o  = (state_q == ST_WR) ? ra_q : ret_addr_i;
  assign ret_fire_o   = (accept && op_i == OP_RET) || (rd_done && fused_q);
  assign ret_target_o = (state_q == ST_RD_WAIT) ? mem_rdata_i : lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fused_q <= 1'b0;
      ra_q    <= '0;
      lr_q    <= '0;
      sp_q    <= SP_INIT;
    end else begin
      unique case (state_q)
        ST_IDLE: if (op_valid_i) begin
          unique case (op_i)
            OP_CALL:      lr_q <= ret_addr_i;
            OP_PUSH:      begin state_q <= ST_WR;     fused_q <= 1'b0; end
            OP_PUSH_CALL: begin state_q <= ST_WR;     fused_q <= 1'b1; ra_q <= ret_addr_i; end
            OP_POP:       begin state_q <= ST_RD_REQ; fused_q <= 1'b0; end
            OP_POP_RET:   begin state_q <= ST_RD_REQ; fused_q <= 1'b1; end
            default: ;  // none, return, indirect jump: no sequencer state
          endcase
        end
        ST_WR: if (mem_req_ready_i) begin
          sp_q    <= sp_q - STEP;
          if (fused_q) lr_q <= ra_q;
          state_q <= ST_IDLE;
        end
        ST_RD_REQ: if (mem_req_ready_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid_i) begin
          lr_q    <= mem_rdata_i;
          sp_q    <= sp_q + STEP;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_sp_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_q) |-> (sp_q == $past(sp_q) + STEP) || (sp_q == $past(sp_q) - STEP));

  assert_leaf_call_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_i == OP_CALL |=> !mem_req_valid_o && lr_q == $past(ret_addr_i));

  assert_jind_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_i == OP_JIND |-> !pred_push_o && !ret_fire_o);
endmodule

// File: rtl/ret_resolve.sv
module ret_resolve #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [AW-1:0] target_i,
  input  logic          top_valid_i,
  input  logic [AW-1:0] top_data_i,
  output logic          ret_valid_o,
  output logic [AW-1:0] ret_target_o,
  output logic          pred_valid_o,
  output logic [AW-1:0] pred_target_o,
  output logic          mispredict_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_valid_o   <= 1'b0;
      ret_target_o  <= '0;
      pred_valid_o  <= 1'b0;
      pred_target_o <= '0;
      mispredict_o  <= 1'b0;
    end else begin
      ret_valid_o <= fire_i;
      if (fire_i) begin
        ret_target_o  <= target_i;
        pred_valid_o  <= top_valid_i;
        pred_target_o <= top_valid_i ? top_data_i : '0;
        mispredict_o  <= !top_valid_i || (top_data_i != target_i);
      end else begin
        pred_valid_o <= 1'b0;
        mispredict_o <= 1'b0;
      end
    end
  end

  assert_nopred_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o && !pred_valid_o |-> mispredict_o);
endmodule

// File: rtl/link_unit.sv
module link_unit
  import link_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   DEPTH      = 8,
  parameter int unsigned   SLOT_BYTES = 8,
  parameter logic [AW-1:0] SP_INIT    = 'h1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] ret_addr_i,
  output logic          op_ready_o,
  output logic [AW-1:0] lr_o,
  output logic [AW-1:0] sp_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          ret_valid_o,
  output logic [AW-1:0] ret_target_o,
  output logic          pred_valid_o,
  output logic [AW-1:0] pred_target_o,
  output logic          mispredict_o
);
  logic          pred_push, ret_fire, top_valid;
  logic [AW-1:0] pred_data, ret_target, top_data;

  link_seq #(.AW(AW), .SLOT_BYTES(SLOT_BYTES), .SP_INIT(SP_INIT)) u_seq (
    .clk_i, .rst_ni, .op_valid_i,
    .op_i(link_op_e'(op_i)),
    .ret_addr_i, .op_ready_o, .lr_o, .sp_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rsp_valid_i, .mem_rdata_i,
    .pred_push_o(pred_push), .pred_data_o(pred_data),
    .ret_fire_o(ret_fire), .ret_target_o(ret_target)
  );

  ret_ring #(.AW(AW), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .push_i(pred_push), .push_data_i(pred_data),
    .pop_i(ret_fire),
    .top_valid_o(top_valid), .top_data_o(top_data)
  );

  ret_resolve #(.AW(AW)) u_res (
    .clk_i, .rst_ni,
    .fire_i(ret_fire), .target_i(ret_target),
    .top_valid_i(top_valid), .top_data_i(top_data),
    .ret_valid_o, .ret_target_o, .pred_valid_o, .pred_target_o, .mispredict_o
  );

  assert_mis_on_ret_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> ret_valid_o);

  assert_busy_no_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !op_ready_o);
endmodule

// File: tb/sim_link_unit.sv
`timescale 1ns/1ps
module sim_link_unit;
  localparam int AW = 32;
  localparam logic [31:0] S = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] ret_addr = '0;
  logic op_ready, mem_req_valid, mem_we, ret_valid, pred_valid, mispredict;
  logic [31:0] lr, sp, mem_addr, mem_wdata, ret_target, pred_target;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_err = 0, stall = 0, wait_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [16];
  logic rd_pend = 1'b0;
  logic [31:0] rd_addr = '0, last_waddr = '0, last_wdata = '0;

  always #2.5 clk = ~clk;

  link_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .ret_addr_i(ret_addr),
    .op_ready_o(op_ready), .lr_o(lr), .sp_o(sp),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata),
    .ret_valid_o(ret_valid), .ret_target_o(ret_target),
    .pred_valid_o(pred_valid), .pred_target_o(pred_target), .mispredict_o(mispredict)
  );

  // memory model: handshake captured at posedge, ready/response driven at negedge
  always @(posedge clk) begin
    rd_pend <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        mem[mem_addr[6:3]] <= mem_wdata;
        last_waddr <= mem_addr;
        last_wdata <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_pend <= 1'b1;
        rd_addr <= mem_addr;
      end
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid <= rd_pend;
    mem_rdata     <= mem[rd_addr[6:3]];
    if (mem_req_valid && wait_cnt < stall) begin
      mem_req_ready <= 1'b0;
      wait_cnt <= wait_cnt + 1;
    end else begin
      mem_req_ready <= mem_req_valid;
      wait_cnt <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] ra);
    @(negedge clk);
    op_valid = 1'b1; op = o; ret_addr = ra;
    @(negedge clk);
    op_valid = 1'b0; op = '0;
  endtask

  task automatic wait_idle();
    while (!op_ready) @(negedge clk);
  endtask

  task automatic chk_ret(input string req, input logic [31:0] tgt, input logic pv,
                         input logic [31:0] pt, input logic mis);
    chk({req, " ret_valid"}, {31'd0, ret_valid}, 32'd1);
    chk({req, " ret_target"}, ret_target, tgt);
    chk({req, " pred_valid"}, {31'd0, pred_valid}, {31'd0, pv});
    if (pv) chk({req, " pred_target"}, pred_target, pt);
    chk({req, " mispredict"}, {31'd0, mispredict}, {31'd0, mis});
  endtask

  task automatic t_reset();
    chk("R1 lr", lr, 32'd0);
    chk("R1 sp", sp, S);
    chk("R1 ready", {31'd0, op_ready}, 32'd1);
    chk("R1 req", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 flags", {29'd0, ret_valid, pred_valid, mispredict}, 32'd0);
  endtask

  task automatic t_leaf_call();
    int w0 = wr_cnt;
    issue(3'd1, 32'h100);
    chk("R2 lr", lr, 32'h100);
    chk("R2 no req", {31'd0, mem_req_valid}, 32'd0);
    @(negedge clk);
    chk("R2 no write", wr_cnt, w0);
  endtask

  task automatic t_return_hit();
    issue(3'd2, 0);
    chk_ret("R3", 32'h100, 1'b1, 32'h100, 1'b0);
    @(negedge clk);
    chk("R3 pulse", {31'd0, ret_valid}, 32'd0);
  endtask

  task automatic t_return_empty();
    issue(3'd2, 0);
    chk_ret("R4 empty", 32'h100, 1'b0, 0, 1'b1);
  endtask

  task automatic t_mismatch();
    issue(3'd1, 32'h300);
    issue(3'd3, 0); wait_idle();
    chk("R7 sp", sp, S - 8);
    issue(3'd1, 32'h400);
    issue(3'd2, 0);
    chk_ret("R3 nest", 32'h400, 1'b1, 32'h400, 1'b0);
    issue(3'd2, 0);
    chk_ret("R4 wrong", 32'h400, 1'b1, 32'h300, 1'b1);
    issue(3'd4, 0); wait_idle();
    chk("R8 lr", lr, 32'h300);
    chk("R8 sp", sp, S);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 10; i++) issue(3'd1, 32'h2000 + 32'(4 * i));
    chk("R2 last lr", lr, 32'h2024);
    for (int k = 0; k < 8; k++) begin
      issue(3'd2, 0);
      chk("R5 pred_valid", {31'd0, pred_valid}, 32'd1);
      chk("R5 pred_target", pred_target, 32'h2000 + 32'(4 * (9 - k)));
    end
    issue(3'd2, 0);
    chk("R5 drained", {31'd0, pred_valid}, 32'd0);
    chk("R5 drained mis", {31'd0, mispredict}, 32'd1);
  endtask

  task automatic t_indirect();
    issue(3'd1, 32'h500);
    issue(3'd7, 32'h9999);
    chk("R6 lr", lr, 32'h500);
    chk("R6 no ret", {31'd0, ret_valid}, 32'd0);
    chk("R6 no req", {31'd0, mem_req_valid}, 32'd0);
    issue(3'd2, 0);
    chk_ret("R6 ring", 32'h500, 1'b1, 32'h500, 1'b0);
  endtask

  task automatic t_push();
    stall = 2;
    issue(3'd3, 0);
    chk("R7 valid", {31'd0, mem_req_valid}, 32'd1);
    chk("R7 we", {31'd0, mem_we}, 32'd1);
    chk("R7 addr", mem_addr, S - 8);
    chk("R7 data", mem_wdata, 32'h500);
    chk("R7 busy", {31'd0, op_ready}, 32'd0);
    @(negedge clk);
    chk("R7 hold", mem_addr, S - 8);
    chk("R7 sp held", sp, S);
    wait_idle();
    chk("R7 sp", sp, S - 8);
    chk("R7 waddr", last_waddr, S - 8);
    chk("R7 wdata", last_wdata, 32'h500);
    stall = 0;
  endtask

  task automatic t_pop();
    issue(3'd1, 32'h600);
    stall = 1;
    issue(3'd4, 0);
    chk("R8 read", {30'd0, mem_req_valid, mem_we}, 32'd2);
    chk("R8 addr", mem_addr, S - 8);
    wait_idle();
    chk("R8 lr", lr, 32'h500);
    chk("R8 sp", sp, S);
    stall = 0;
  endtask

  task automatic t_push_call();
    issue(3'd5, 32'h700); wait_idle();
    chk("R9 wdata", last_wdata, 32'h500);
    chk("R9 waddr", last_waddr, S - 8);
    chk("R9 lr", lr, 32'h700);
    chk("R9 sp", sp, S - 8);
    issue(3'd2, 0);
    chk_ret("R9 ring", 32'h700, 1'b1, 32'h700, 1'b0);
  endtask

  task automatic t_pop_ret();
    issue(3'd6, 0); wait_idle();
    chk_ret("R10 miss", 32'h500, 1'b1, 32'h600, 1'b1);
    chk("R10 lr", lr, 32'h500);
    chk("R10 sp", sp, S);
    // nested non-leaf: call, fused save+call, leaf return, fused restore+return
    issue(3'd1, 32'h900);
    issue(3'd5, 32'hA00); wait_idle();
    issue(3'd2, 0);
    chk_ret("R10 inner", 32'hA00, 1'b1, 32'hA00, 1'b0);
    issue(3'd6, 0); wait_idle();
    chk_ret("R10 outer", 32'h900, 1'b1, 32'h900, 1'b0);
    chk("R10 sp2", sp, S);
    issue(3'd2, 0);
    chk("R10 empty", {31'd0, pred_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_leaf_call();
    t_return_hit();
    t_return_empty();
    t_mismatch();
    t_overflow();
    t_indirect();
    t_push();
    t_pop();
    t_push_call();
    t_pop_ret();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule